// File: doc/BRIEF.md
# Reset Cause Recorder with One-Shot Reset Generator

This block lets software start a short chip-wide or CPU-only reset, and it keeps a record of what caused the last reset. Two self-clearing control bits start the resets. They only take effect while the unlock input from the key block is high. The chip reset pulse also drives the CPU reset and every peripheral reset line. It clears the peripheral reset register and marks itself as a power-on cause. The CPU-only pulse resets the CPU core and the flash controller, and it has a cause flag of its own.

Reset events from outside the block arrive as single-cycle pulses: the reset pin, the watchdog, brown-out and the CPU's system-reset request. Each pulse sets a sticky flag in the cause register, and software clears a flag by writing 1 to it. The cause register is reset only by true power-on, through `por_n`, so it survives the chip resets it records. A third register holds one level-sensitive reset bit for each peripheral.

Software reaches the registers through one write port and one combinational read port, each with a 2-bit select: 0 control, 1 cause, 2 peripheral, 3 unused.

Top module: `sysrst_recorder`

## Requirements
- R1: A control write (select 0) with data bit 0 set, made while `unlock` is high, raises `chip_rst_o` for exactly two cycles, starting in the cycle after the write edge.
- R2: A control write with data bit 1 set, made while `unlock` is high, raises `cpu_rst_o` for exactly two cycles, and `chip_rst_o` stays low during that pulse. The CPU-only pulse sets cause bit 7.
- R3: A control write made while `unlock` is low starts no pulse and leaves the control read-back at 0.
- R4: While the chip pulse is active, `cpu_rst_o` is high and all nine `periph_rst_o` lines are high. The peripheral register reads 0 after the pulse, and cause bit 0 is set.
- R5: One-cycle pulses on `ev_pin`, `ev_wdt`, `ev_bod` and `ev_sysreq` set cause bits 1, 2, 4 and 5. Cause bits 3, 6 and 8 to 31 always read 0.
- R6: Writing 1 to a cause bit (select 1) clears it, and writing 0 to a bit leaves it unchanged. When an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R7: Cause flags keep their value through a chip pulse. Power-on (`por_n` low) sets the cause register to 0x01 and clears the control and peripheral registers.
- R8: The peripheral register (select 2) stores bits 1, 2, 3, 8, 12, 16, 20, 22 and 28. These bits drive `periph_rst_o[0]` to `periph_rst_o[8]` in that order (GPIO, timer0, timer1, I2C, SPI, UART, PWM, comparator, ADC). The bits stay set until software rewrites them, and all other bits read 0.
- R9: Read select 0 returns the chip pulse state at bit 0 and the CPU pulse state at bit 1. Read select 3 returns 0.
- R10: A new trigger of a pulse that is already active is ignored, so the pulse is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| unlock | input | 1 | Protection open, from the key block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 cause, 2 peripheral |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel`, 3 reads 0 |
| rd_data | output | 32 | Combinational read data |
| ev_pin | input | 1 | Reset pin event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_bod | input | 1 | Brown-out reset event pulse |
| ev_sysreq | input | 1 | CPU system-reset request pulse |
| chip_rst_o | output | 1 | Chip-wide reset pulse |
| cpu_rst_o | output | 1 | CPU core and flash controller reset |
| periph_rst_o | output | 9 | Per-peripheral reset lines |

## Verification
The two hardest cases to reach are collisions within a single cycle.

The first is an event arriving in the same cycle as a write-1 clear of the same flag. The bench drives `ev_wdt` and a cause write with the same bit in one cycle.

The second is a re-trigger of a chip pulse that is already active. The bench issues a second unlocked control write on the cycle right after the first, while the pulse is active.

Proving that cause flags survive a chip pulse, yet not a power-on, requires first loading the cause register with a mix of flags. The bench then fires a chip pulse and finally drops `por_n` in the middle of the run.

// File: rtl/rstrec_pkg.sv
package rstrec_pkg;

    localparam int DATA_W   = 32;
    localparam int CAUSE_W  = 8;
    localparam int PERIPH_N = 9;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_CAUSE  = 2'd1;
    localparam logic [1:0] SEL_PERIPH = 2'd2;

    localparam int CAUSE_POR    = 0;
    localparam int CAUSE_PIN    = 1;
    localparam int CAUSE_WDT    = 2;
    localparam int CAUSE_BOD    = 4;
    localparam int CAUSE_SYSREQ = 5;
    localparam int CAUSE_CPU    = 7;

    localparam logic [CAUSE_W-1:0] CAUSE_MASK =
        CAUSE_W'((1 << CAUSE_POR) | (1 << CAUSE_PIN) | (1 << CAUSE_WDT) |
                 (1 << CAUSE_BOD) | (1 << CAUSE_SYSREQ) | (1 << CAUSE_CPU));

    localparam logic [CAUSE_W-1:0] CAUSE_RESET = CAUSE_W'(1 << CAUSE_POR);

    // Register bit of each peripheral reset line, line 0 first.
    localparam int PERIPH_POS [PERIPH_N] = '{1, 2, 3, 8, 12, 16, 20, 22, 28};

endpackage

// File: rtl/rstrec_oneshot.sv
module rstrec_oneshot #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic accept,
    output logic active
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam int LW = $clog2(PULSE_LEN + 2);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] left;
    } shot_t;

    shot_t shot_d, shot_q;

    always_comb begin
        shot_d = shot_q;
        accept = fire && !shot_q.on;
        if (accept) begin
            shot_d.on   = 1'b1;
            shot_d.left = CW'(PULSE_LEN - 1);
        end else if (shot_q.on) begin
            if (shot_q.left == '0) begin
                shot_d.on = 1'b0;
            end else begin
                shot_d.left = shot_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shot_q <= '0;
        end else begin
            shot_q <= shot_d;
        end
    end

    assign active = shot_q.on;

    // Length counter used only by the check below.
    logic [LW-1:0] len_d, len_q;
    always_comb len_d = shot_q.on ? len_q + 1'b1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    // R1 / R2 / R10: every pulse lasts exactly PULSE_LEN cycles
    a_r1_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shot_q.on) |-> (len_q == LW'(PULSE_LEN)));

endmodule

// File: rtl/rstrec_causes.sv
module rstrec_causes
    import rstrec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic [CAUSE_W-1:0] clr_vec,
    output logic [CAUSE_W-1:0] flags_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] flags;
    } cause_t;

    cause_t cause_d, cause_q;

    always_comb begin
        cause_d       = cause_q;
        cause_d.flags = ((cause_q.flags & ~clr_vec) | set_vec) & CAUSE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q.flags <= CAUSE_RESET;
        end else begin
            cause_q <= cause_d;
        end
    end

    assign flags_o = cause_q.flags;

    // R6: a set in the same cycle as a clear still leaves the flag set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((cause_q.flags & $past(set_vec)) == $past(set_vec)));

    // R6: with no clear and no event the flags hold
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(cause_q.flags));

endmodule

// File: rtl/rstrec_periph.sv
module rstrec_periph
    import rstrec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [PERIPH_N-1:0] lines_o
);
    typedef struct packed {
        logic [PERIPH_N-1:0] bits;
    } preg_t;

    preg_t preg_d, preg_q;
    logic [PERIPH_N-1:0] wr_bits;
    wire unused_wdata = ^wdata;

    for (genvar i = 0; i < PERIPH_N; i++) begin : g_field
        assign wr_bits[i] = wdata[PERIPH_POS[i]];
        assign lines_o[i] = preg_q.bits[i] | clear;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < PERIPH_N; i++) begin
            rdata[PERIPH_POS[i]] = preg_q.bits[i];
        end
    end

    always_comb begin
        preg_d = preg_q;
        if (clear) begin
            preg_d.bits = '0;
        end else if (we) begin
            preg_d.bits = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preg_q <= '0;
        end else begin
            preg_q <= preg_d;
        end
    end

    // R4: the chip pulse empties the peripheral register
    a_r4_chip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (preg_q.bits == '0));

    // R8: bits are not self-clearing
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !we) |=> $stable(preg_q.bits));

endmodule

// File: rtl/sysrst_recorder.sv
module sysrst_recorder
    import rstrec_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                unlock,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [1:0]          rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                ev_pin,
    input  logic                ev_wdt,
    input  logic                ev_bod,
    input  logic                ev_sysreq,
    output logic                chip_rst_o,
    output logic                cpu_rst_o,
    output logic [PERIPH_N-1:0] periph_rst_o
);
    typedef struct packed {
        logic               ctrl_wr;
        logic               cause_wr;
        logic               periph_wr;
        logic               chip_fire;
        logic               cpu_fire;
        logic [CAUSE_W-1:0] set_vec;
        logic [CAUSE_W-1:0] clr_vec;
    } dec_t;

    dec_t dec;

    logic chip_accept, chip_on;
    logic cpu_accept,  cpu_on;
    logic [CAUSE_W-1:0] flags;
    logic [DATA_W-1:0]  periph_rdata;

    always_comb begin
        dec           = '0;
        dec.ctrl_wr   = wr_en && (wr_sel == SEL_CTRL) && unlock;
        dec.cause_wr  = wr_en && (wr_sel == SEL_CAUSE);
        dec.periph_wr = wr_en && (wr_sel == SEL_PERIPH);
        dec.chip_fire = dec.ctrl_wr && wr_data[0];
        dec.cpu_fire  = dec.ctrl_wr && wr_data[1];
        dec.clr_vec   = dec.cause_wr ? wr_data[CAUSE_W-1:0] : '0;
        dec.set_vec[CAUSE_POR]    = chip_accept;
        dec.set_vec[CAUSE_PIN]    = ev_pin;
        dec.set_vec[CAUSE_WDT]    = ev_wdt;
        dec.set_vec[CAUSE_BOD]    = ev_bod;
        dec.set_vec[CAUSE_SYSREQ] = ev_sysreq;
        dec.set_vec[CAUSE_CPU]    = cpu_accept;
    end

    rstrec_oneshot #(.PULSE_LEN(PULSE_LEN)) u_chip_shot (
        .clk    (clk),
        .rst_n  (por_n),
        .fire   (dec.chip_fire),
        .accept (chip_accept),
        .active (chip_on)
    );

    rstrec_oneshot #(.PULSE_LEN(PULSE_LEN)) u_cpu_shot (
        .clk    (clk),
        .rst_n  (por_n),
        .fire   (dec.cpu_fire),
        .accept (cpu_accept),
        .active (cpu_on)
    );

    rstrec_causes u_causes (
        .clk     (clk),
        .rst_n   (por_n),
        .set_vec (dec.set_vec),
        .clr_vec (dec.clr_vec),
        .flags_o (flags)
    );

    rstrec_periph u_periph (
        .clk     (clk),
        .rst_n   (por_n),
        .clear   (chip_on),
        .we      (dec.periph_wr),
        .wdata   (wr_data),
        .rdata   (periph_rdata),
        .lines_o (periph_rst_o)
    );

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL:   rd_data[1:0]         = {cpu_on, chip_on};
            SEL_CAUSE:  rd_data[CAUSE_W-1:0] = flags;
            SEL_PERIPH: rd_data              = periph_rdata;
            default:    rd_data              = '0;
        endcase
    end

    assign chip_rst_o = chip_on;
    assign cpu_rst_o  = chip_on | cpu_on;

    // R3: a locked control write never starts the chip pulse
    a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_sel == SEL_CTRL && !unlock && !chip_rst_o) |=> !chip_rst_o);

    // R4: the chip pulse is recorded as a power-on cause
    a_r4_chip_flag: assert property (@(posedge clk) disable iff (!por_n)
        $rose(chip_rst_o) |-> flags[CAUSE_POR]);

    // R5: unimplemented cause bits stay low
    a_r5_unused_low: assert property (@(posedge clk) disable iff (!por_n)
        (flags & ~CAUSE_MASK) == '0);

endmodule

// File: tb/test_sysrst_recorder.sv
module test_sysrst_recorder;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        unlock = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        ev_pin = 1'b0, ev_wdt = 1'b0, ev_bod = 1'b0, ev_sysreq = 1'b0;
    logic        chip_rst_o, cpu_rst_o;
    logic [8:0]  periph_rst_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sysrst_recorder i_sysrst_recorder (
        .clk(clk), .por_n(por_n), .unlock(unlock), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ev_pin(ev_pin), .ev_wdt(ev_wdt), .ev_bod(ev_bod), .ev_sysreq(ev_sysreq),
        .chip_rst_o(chip_rst_o), .cpu_rst_o(cpu_rst_o), .periph_rst_o(periph_rst_o)
    );

    // ---------------- behavioural reference model ----------------
    int          m_chip = 0;
    int          m_cpu = 0;
    logic [7:0]  m_flags = 8'h01;
    logic [31:0] m_periph = '0;
    int          line_pos [9] = '{1, 2, 3, 8, 12, 16, 20, 22, 28};

    function automatic logic [8:0] m_lines();
        logic [8:0] l;
        for (int i = 0; i < 9; i++) l[i] = m_periph[line_pos[i]] | (m_chip > 0);
        return l;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] s);
        case (s)
            2'd0:    return {30'd0, m_cpu > 0, m_chip > 0};
            2'd1:    return {24'd0, m_flags};
            2'd2:    return m_periph;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!por_n) begin
            m_chip = 0; m_cpu = 0; m_flags = 8'h01; m_periph = '0;
        end else begin
            bit chip_on, cpu_on, ctrl_wr, chip_go, cpu_go;
            logic [7:0] setv, clrv;
            chip_on = m_chip > 0;
            cpu_on  = m_cpu > 0;
            ctrl_wr = wr_en && wr_sel == 2'd0 && unlock;
            chip_go = ctrl_wr && wr_data[0] && !chip_on;
            cpu_go  = ctrl_wr && wr_data[1] && !cpu_on;
            setv = {cpu_go, 1'b0, ev_sysreq, ev_bod, 1'b0, ev_wdt, ev_pin, chip_go};
            clrv = (wr_en && wr_sel == 2'd1) ? wr_data[7:0] : 8'h00;
            m_flags = ((m_flags & ~clrv) | setv) & 8'hB7;
            if (chip_go) m_chip = 2; else if (m_chip > 0) m_chip--;
            if (cpu_go)  m_cpu  = 2; else if (m_cpu > 0)  m_cpu--;
            if (chip_on) m_periph = '0;
            else if (wr_en && wr_sel == 2'd2) m_periph = wr_data & 32'h1051_110E;
        end
        #5;
        chk("R1", {31'd0, chip_rst_o}, {31'd0, m_chip > 0});
        chk("R2", {31'd0, cpu_rst_o}, {31'd0, (m_chip > 0) || (m_cpu > 0)});
        chk("R8", {23'd0, periph_rst_o}, {23'd0, m_lines()});
        chk("R9", rd_data, m_read(rd_sel));
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic u);
        wr_en = 1'b1; wr_sel = s; wr_data = d; unlock = u;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; unlock = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] s, input logic [31:0] exp);
        rd_sel = s;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic bit1(input string tag, input logic got, input logic exp);
        chk(tag, {31'd0, got}, {31'd0, exp});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cyc >= 20000);
        failures++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rdchk("R7", 2'd1, 32'h01);
        rdchk("R9", 2'd0, 32'h0);
        bit1("R1", chip_rst_o, 1'b0);

        // locked write
        wr(2'd0, 32'h3, 1'b0);
        bit1("R3", chip_rst_o, 1'b0);
        bit1("R3", cpu_rst_o, 1'b0);
        rdchk("R3", 2'd0, 32'h0);
        rdchk("R3", 2'd1, 32'h01);

        // peripheral register load
        wr(2'd2, 32'hFFFF_FFFF, 1'b0);
        rdchk("R8", 2'd2, 32'h1051_110E);
        chk("R8", {23'd0, periph_rst_o}, 32'h1FF);
        wr(2'd1, 32'h01, 1'b0);
        rdchk("R6", 2'd1, 32'h00);

        // chip pulse with a re-trigger on its first cycle
        wr(2'd0, 32'h1, 1'b1);
        bit1("R1", chip_rst_o, 1'b1);
        bit1("R4", cpu_rst_o, 1'b1);
        chk("R4", {23'd0, periph_rst_o}, 32'h1FF);
        wr(2'd0, 32'h1, 1'b1);
        bit1("R10", chip_rst_o, 1'b1);
        @(negedge clk);
        bit1("R10", chip_rst_o, 1'b0);
        rdchk("R4", 2'd2, 32'h0);
        rdchk("R4", 2'd1, 32'h01);
        chk("R4", {23'd0, periph_rst_o}, 32'h0);

        // CPU-only pulse
        wr(2'd0, 32'h2, 1'b1);
        bit1("R2", cpu_rst_o, 1'b1);
        bit1("R2", chip_rst_o, 1'b0);
        rdchk("R9", 2'd0, 32'h2);
        @(negedge clk);
        bit1("R2", cpu_rst_o, 1'b1);
        @(negedge clk);
        bit1("R2", cpu_rst_o, 1'b0);
        rdchk("R2", 2'd1, 32'h81);

        // external events
        ev_pin = 1'b1; @(negedge clk); ev_pin = 1'b0;
        ev_wdt = 1'b1; @(negedge clk); ev_wdt = 1'b0;
        ev_bod = 1'b1; ev_sysreq = 1'b1; @(negedge clk);
        ev_bod = 1'b0; ev_sysreq = 1'b0;
        rdchk("R5", 2'd1, 32'hB7);

        // write-one-clear and priority
        wr(2'd1, 32'h0, 1'b0);
        rdchk("R6", 2'd1, 32'hB7);
        wr(2'd1, 32'h06, 1'b0);
        rdchk("R6", 2'd1, 32'hB1);
        ev_wdt = 1'b1;
        wr(2'd1, 32'h04, 1'b0);
        ev_wdt = 1'b0;
        rdchk("R6", 2'd1, 32'hB5);

        // flags survive a chip pulse, not a power-on
        wr(2'd2, 32'h0000_0102, 1'b0);
        wr(2'd0, 32'h1, 1'b1);
        repeat (3) @(negedge clk);
        rdchk("R7", 2'd1, 32'hB5);
        wr(2'd2, 32'h0000_0102, 1'b0);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rdchk("R7", 2'd1, 32'h01);
        rdchk("R7", 2'd2, 32'h0);

        // peripheral bits hold
        wr(2'd2, 32'h0000_0102, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8", {23'd0, periph_rst_o}, 32'h009);
        rdchk("R8", 2'd2, 32'h0000_0102);
        rdchk("R9", 2'd3, 32'h0);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule